// File: doc/BRIEF.md
# Two-Wire Register-File Slave with Command Pointer

This block is a two-wire serial (I2C-compatible) slave that sits in front of a small register file. It runs entirely on the system clock. It synchronises the bus lines and recognises START, repeated START and STOP. It accepts one of two 7-bit addresses, chosen by a strap input, and acknowledges each byte it receives.

Register access goes through a stored command pointer. In a write transaction, the first byte after the address is the new pointer value, and every later byte is written to the register the pointer selects. A read transaction returns bytes starting at whatever the pointer currently holds. After each data byte, written or read, the pointer advances by one, except at 0x7F, where it stays. The register file itself lives outside the block. The block offers it a simple port: an address, write data with a write strobe, read data, and a read strobe that lets clear-on-read registers react.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block responds only to the 7-bit address whose upper six bits are 011100 and whose lowest bit equals `addr_lsb`. Any other address receives no acknowledge, and the transaction causes no register strobe.
- R2: In a write transaction, the first byte after the address is stored as the pointer. Each later byte is presented on `reg_wdata` with a one-cycle `reg_we` pulse, while `reg_addr` shows the current pointer.
- R3: A STOP directly after the pointer byte changes only the pointer; no `reg_we` pulse occurs.
- R4: After every data byte written or read, the pointer increases by one. When the pointer is 0x7F it stays at 0x7F.
- R5: A read transaction returns data starting at the stored pointer. This holds after a repeated START that follows the pointer write, and it holds when the read continues from the pointer left by an earlier transaction.
- R6: Bytes written while the pointer is 0x08 or 0x0C are acknowledged, but they produce no `reg_we` pulse; the pointer still advances.
- R7: Bytes are sent MSB first. The slave pulls SDA low for its acknowledge and for 0 data bits. During the master's ACK/NACK bit it does not drive SDA, and after a NACK it leaves SDA released until the next START.
- R8: Each byte read produces exactly one one-cycle `reg_re` pulse when the master's ACK/NACK bit is sampled. During that pulse, `reg_addr` holds the address of the byte just sent.
- R9: After reset, `sda_oe`, `reg_we` and `reg_re` are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| addr_lsb | input | 1 | Strap that selects the lowest slave-address bit |
| sda_oe | output | 1 | High to pull SDA low |
| reg_addr | output | 8 | Register address (the stored pointer) |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle strobe after a register byte has been read |
| reg_rdata | input | 8 | Data of the register selected by `reg_addr` |

## Verification
The hardest state to reach is a pointer held at 0x7F while bytes keep arriving. The bench gets there in two ways. One is a short burst that starts at 0x7E. The other is a sweep that writes every address from 0x00 upward in one transaction and then reads two bytes past the end. Between them they also cover the two read-only addresses in the middle of a burst. The other hard case is a read that continues from the pointer of an earlier transaction. The bench sets this up by issuing reads with no pointer byte after earlier writes, reads and a STOP that came straight after a pointer byte. In every such case it predicts the data from its own model of the pointer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 8;
    localparam int BIT_CW = 4;

    localparam logic [5:0]       DEV_ADDR_HI = 6'b011100;
    localparam logic [PTR_W-1:0] PTR_LAST    = 8'h7F;
    localparam logic [PTR_W-1:0] RO_ADDR_A   = 8'h08;
    localparam logic [PTR_W-1:0] RO_ADDR_B   = 8'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_event_t;

    function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? p : p + 1'b1;
    endfunction

    function automatic logic is_read_only(input logic [PTR_W-1:0] p);
        return (p == RO_ADDR_A) || (p == RO_ADDR_B);
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_s,
    input  logic       sda_s,
    output bus_event_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_lsb,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam logic [BIT_CW-1:0] BITS_DONE = BIT_CW'(DATA_W);
    localparam logic [BIT_CW-1:0] LAST_BIT  = BIT_CW'(DATA_W - 1);

    logic [1:0]        line_s;
    bus_event_t        ev;
    slv_state_e        state;
    logic [BIT_CW-1:0] bitcnt;
    logic [DATA_W-1:0] rx_sh, tx_sh;
    logic [PTR_W-1:0]  ptr;
    logic              first_byte, is_read, master_ack, bump;

    i2cs_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw({scl_i, sda_i}), .synced(line_s)
    );

    i2cs_cond_detect u_cond (
        .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]), .ev(ev)
    );

    assign reg_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            first_byte <= 1'b0;
            is_read    <= 1'b0;
            master_ack <= 1'b0;
            bump       <= 1'b0;
            sda_oe     <= 1'b0;
            reg_we     <= 1'b0;
            reg_re     <= 1'b0;
            reg_wdata  <= '0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            bump   <= 1'b0;
            if (bump) ptr <= ptr_advance(ptr);

            if (ev.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.scl_rise && bitcnt != BITS_DONE) begin
                            rx_sh  <= {rx_sh[DATA_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == BITS_DONE) begin
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] == {DEV_ADDR_HI, addr_lsb}) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= rx_sh[0];
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                                if (first_byte) begin
                                    ptr        <= rx_sh;
                                    first_byte <= 1'b0;
                                end else begin
                                    reg_we    <= !is_read_only(ptr);
                                    reg_wdata <= rx_sh;
                                    bump      <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[DATA_W-1];
                                state  <= ST_RD_BYTE;
                            end else begin
                                sda_oe     <= 1'b0;
                                first_byte <= 1'b1;
                                state      <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                                sda_oe <= ~tx_sh[DATA_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            master_ack <= ~ev.sda;
                            reg_re     <= 1'b1;
                            bump       <= 1'b1;
                        end else if (ev.scl_fall) begin
                            if (master_ack) begin
                                bitcnt <= '0;
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[DATA_W-1];
                                state  <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input slv_state_e       state,
    input logic             sda_oe,
    input logic             reg_we,
    input logic             reg_re,
    input logic [PTR_W-1:0] reg_addr
);
    assert_we_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        ((reg_we || reg_re) && reg_addr != PTR_LAST) |=> reg_addr == $past(reg_addr) + 1'b1);

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((reg_we || reg_re) && reg_addr == PTR_LAST) |=> reg_addr == PTR_LAST);

    assert_no_ro_write_R6: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_addr != RO_ADDR_A && reg_addr != RO_ADDR_B));

    assert_release_master_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK) |-> !sda_oe);

    assert_re_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    assert_strobes_apart_R8: assert property (@(posedge clk) disable iff (rst)
        !(reg_re && reg_we));
endmodule

bind i2c_regfile_slave i2cs_checker u_chk (
    .clk(clk), .rst(rst), .state(state), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b1;
    logic sda_oe, reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_bus;

    logic [7:0] mem [256];
    logic [7:0] expv [256];
    int checks = 0, failures = 0;
    int we_count = 0, re_count = 0;
    logic [7:0] re_last_addr = 8'h00;
    logic [7:0] mptr = 8'h00;
    logic done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regfile_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .addr_lsb(strap),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
        if (reg_re) begin
            re_count <= re_count + 1;
            re_last_addr <= reg_addr;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = ~sda_bus;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_m = 1'b1; wq();
            b = {b[6:0], sda_bus};
            wq();
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; wq();
        scl_m = 1'b1; wq();
        check(sda_oe == 1'b0, "R7 slave released during master ack bit", sda_oe, 0);
        wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic lsb, input logic rd);
        return {6'b011100, lsb, rd};
    endfunction

    task automatic model_write(input logic [7:0] b);
        if (mptr != 8'h08 && mptr != 8'h0C) expv[mptr] = b;
        if (mptr != 8'h7F) mptr = mptr + 8'd1;
    endtask

    task automatic model_read_step();
        if (mptr != 8'h7F) mptr = mptr + 8'd1;
    endtask

    task automatic do_write(input logic [7:0] cmd, input int n, input int seed, input string req);
        logic a;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a);
        check(a, req, a, 1);
        send_byte(cmd, a);
        check(a, req, a, 1);
        mptr = cmd;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'((i * 29 + seed) & 8'hFF);
            send_byte(v, a);
            check(a, req, a, 1);
            model_write(v);
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, input string req);
        logic a;
        logic [7:0] b;
        send_byte(dev_byte(strap, 1'b1), a);
        check(a, req, a, 1);
        for (int i = 0; i < n; i++) begin
            int re0;
            re0 = re_count;
            recv_byte(i != n - 1, b);
            check(b == expv[mptr], req, b, expv[mptr]);
            check(re_count == re0 + 1 && re_last_addr == mptr,
                  "R8 read strobe count/address", re_last_addr, mptr);
            model_read_step();
        end
        wq();
        check(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        logic a;
        int we0;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'((i * 7 + 3) & 8'hFF);
            expv[i] = 8'((i * 7 + 3) & 8'hFF);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R9 strobes low", {sda_oe, reg_we, reg_re}, 0);
        check(reg_addr == 8'h00, "R9 pointer zero", reg_addr, 0);
        mptr = 8'h00;
        bus_start();
        do_read(1, "R9 first read from pointer 0");

        // R1 wrong address: no ACK, no strobes
        we0 = we_count;
        bus_start();
        send_byte(dev_byte(1'b0, 1'b0), a);
        check(!a, "R1 foreign address not acked", a, 0);
        send_byte(8'h33, a);
        send_byte(8'h44, a);
        bus_stop();
        check(we_count == we0, "R1 no write on foreign address", we_count, we0);
        // R1 other strap value
        strap = 1'b0;
        do_write(8'h30, 1, 90, "R1 strap selects address");
        bus_start();
        send_byte(dev_byte(1'b0, 1'b0), a);
        send_byte(8'h30, a);
        mptr = 8'h30;
        bus_rstart();
        do_read(1, "R1 readback with strap 0");
        strap = 1'b1;

        // R2 / R5 burst write, repeated START read
        do_write(8'h10, 3, 5, "R2 burst write acks");
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a);
        send_byte(8'h10, a);
        mptr = 8'h10;
        bus_rstart();
        do_read(3, "R5 read after repeated START");
        // R5 continue from left pointer
        bus_start();
        do_read(2, "R5 read continues from stored pointer");

        // R3 STOP after command byte
        we0 = we_count;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a);
        send_byte(8'h40, a);
        bus_stop();
        mptr = 8'h40;
        check(we_count == we0, "R3 no write after command-only", we_count, we0);
        bus_start();
        do_read(1, "R3 pointer updated by command-only write");

        // R4 saturation at 0x7F
        do_write(8'h7E, 3, 17, "R4 write across 0x7F");
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a);
        send_byte(8'h7E, a);
        mptr = 8'h7E;
        bus_rstart();
        do_read(3, "R4 pointer holds at 0x7F");

        // R6 read-only addresses inside a burst
        we0 = we_count;
        do_write(8'h07, 3, 200, "R6 read-only write acked");
        check(we_count == we0 + 2, "R6 read-only write dropped", we_count, we0 + 2);
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a);
        send_byte(8'h07, a);
        mptr = 8'h07;
        bus_rstart();
        do_read(3, "R6 read-only value unchanged");

        // R2 R4 sweep of whole space, read past the end
        do_write(8'h00, 130, 11, "R2 sweep write");
        bus_start();
        send_byte(dev_byte(strap, 1'b0), a);
        send_byte(8'h00, a);
        mptr = 8'h00;
        bus_rstart();
        do_read(130, "R4 sweep read");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule